// File: doc/BRIEF.md
# Asynchronous Exception Routing Unit

This unit decides, cycle by cycle, whether pending asynchronous and abort events are handed to the highest privilege level (the monitor level). It watches four level-sensitive sources: a normal interrupt, a fast interrupt, an asynchronous error, and a synchronous external abort. For each one it weighs the current privilege level, the abort mask bit of the processor state, and five routing controls from the monitor's configuration. Each source then has one of three outcomes. It may be taken to the monitor level. It may be left to routing logic below the monitor, which this unit does not model and signals by not asserting a take. Or it may be held pending until its condition changes.

The outputs are registered. In the cycle after a qualifying input cycle, one take line pulses, and a 2-bit code names the vector class used for that entry. Only one source is taken per cycle, chosen by a fixed priority. A synchronous abort taken to the monitor level can be steered to the asynchronous-error vector class by a configuration bit. An asynchronous error raised while executing at the monitor level can be made to ignore the abort mask.

Top module: `exr_route_top`

## Requirements
- R1: While reset is asserted and in the first sampled cycle after release with no requests, every take output is 0 and the vector code is 2'b00.
- R2: A normal-interrupt request is taken (take_irq high one cycle later) exactly when route_irq is 1, at every level including the monitor level 3. With route_irq at 0 it is never taken, at the monitor level included.
- R3: The fast interrupt follows the same rule as R2, using route_fiq and take_fiq.
- R4: With route_abt at 0, an asynchronous error is never taken at any level. With route_abt at 1 and the current level below 3, it is always taken.
- R5: At level 3 with route_abt at 1, an asynchronous error is held pending (no take) while pmask_abt is 1 and abt_nomask is 0. It is taken when pmask_abt is 0 or abt_nomask is 1.
- R6: A synchronous abort is always taken at level 3, whatever route_abt is. Below level 3 it is taken only when route_abt is 1.
- R7: A taken synchronous abort reports vector code 2'b11 when abt_vec_async is 1 and 2'b00 when it is 0.
- R8: The vector code is 2'b01 for a taken normal interrupt and 2'b10 for a taken fast interrupt. It is 2'b11 for a taken asynchronous error, and 2'b00 in a cycle with no take.
- R9: When several sources qualify in one cycle, only the highest is taken. The order from highest is synchronous abort, asynchronous error, fast interrupt, normal interrupt. At most one take output is high per cycle.
- R10: Requests are level-sensitive. A request held while it does not qualify is taken in the cycle after its condition starts to qualify. A request dropped before it ever qualifies is never taken. A request that stays high and qualified is taken again every cycle.
- R11: abt_nomask has no effect when route_abt is 0: the asynchronous error stays untaken at level 3 with the mask clear or set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | LVL_W | Current privilege level; the all-ones value is the monitor level |
| pmask_abt | input | 1 | Processor-state abort mask bit |
| req_irq | input | 1 | Pending normal interrupt |
| req_fiq | input | 1 | Pending fast interrupt |
| req_aerr | input | 1 | Pending asynchronous error |
| req_sabt | input | 1 | Synchronous external abort event |
| route_irq | input | 1 | Route normal interrupts to the monitor level |
| route_fiq | input | 1 | Route fast interrupts to the monitor level |
| route_abt | input | 1 | Route aborts and asynchronous errors to the monitor level |
| abt_nomask | input | 1 | Asynchronous error at monitor level ignores pmask_abt |
| abt_vec_async | input | 1 | Synchronous aborts taken to the monitor use the asynchronous-error vector class |
| take_sabt | output | 1 | Synchronous abort taken (registered pulse) |
| take_aerr | output | 1 | Asynchronous error taken (registered pulse) |
| take_fiq | output | 1 | Fast interrupt taken (registered pulse) |
| take_irq | output | 1 | Normal interrupt taken (registered pulse) |
| vec_cls | output | 2 | Vector class code of the current take |

## Verification
The bench builds the unit with the default LVL_W of 2. This makes level 3 the monitor level and gives levels 0 to 2 as the lower levels, so the split between monitor and lower-level behaviour is reached directly. That size also keeps every combination of level, abort mask, the four requests and the five routing bits small enough to sweep in full against a model. The sweep covers every priority collision and every masking case. Directed scenarios cover the held-pending and release sequences that a single-cycle sweep cannot show.

// File: rtl/exr_pkg.sv
package exr_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_SABT = 0;  // index order is the priority order
  localparam int SRC_AERR = 1;
  localparam int SRC_FIQ  = 2;
  localparam int SRC_IRQ  = 3;

  typedef enum logic [1:0] {
    VC_SYNC = 2'b00,
    VC_IRQ  = 2'b01,
    VC_FIQ  = 2'b10,
    VC_AERR = 2'b11
  } vec_cls_e;

  typedef struct packed {
    logic irq;
    logic fiq;
    logic abt;
    logic nomask;
    logic abt_vec_async;
  } route_cfg_t;

  // asynchronous error: off without routing; at monitor level obeys mask unless nomask
  function automatic logic aerr_ok(logic route_abt, logic at_top, logic pmask, logic nomask);
    return route_abt & (~at_top | ~pmask | nomask);
  endfunction

  // synchronous abort: always at monitor level, below it only when routed
  function automatic logic sabt_ok(logic route_abt, logic at_top);
    return route_abt | at_top;
  endfunction

  function automatic vec_cls_e vec_of(logic [NSRC-1:0] grant, logic abt_vec_async);
    vec_cls_e v;
    v = VC_SYNC;
    if (grant[SRC_SABT])      v = abt_vec_async ? VC_AERR : VC_SYNC;
    else if (grant[SRC_AERR]) v = VC_AERR;
    else if (grant[SRC_FIQ])  v = VC_FIQ;
    else if (grant[SRC_IRQ])  v = VC_IRQ;
    return v;
  endfunction
endpackage

// File: rtl/exr_qualify.sv
module exr_qualify
  import exr_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             pmask_abt,
  input  logic [NSRC-1:0]  req,
  input  route_cfg_t       cfg,
  output logic             at_top,
  output logic [NSRC-1:0]  elig
);
  localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

  always_comb begin
    at_top         = (cur_lvl == TOP_LVL);
    elig           = '0;
    elig[SRC_SABT] = req[SRC_SABT] & sabt_ok(cfg.abt, at_top);
    elig[SRC_AERR] = req[SRC_AERR] & aerr_ok(cfg.abt, at_top, pmask_abt, cfg.nomask);
    elig[SRC_FIQ]  = req[SRC_FIQ]  & cfg.fiq;
    elig[SRC_IRQ]  = req[SRC_IRQ]  & cfg.irq;
  end
endmodule

// File: rtl/exr_arbiter.sv
module exr_arbiter
  import exr_pkg::*;
(
  input  logic [NSRC-1:0] elig,
  output logic [NSRC-1:0] grant
);
  // blocked[i] is high when any higher-priority source (lower index) is eligible
  logic [NSRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    assign grant[i]     = elig[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | elig[i];
  end
endmodule

// File: rtl/exr_route_top.sv
module exr_route_top
  import exr_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             pmask_abt,
  input  logic             req_irq,
  input  logic             req_fiq,
  input  logic             req_aerr,
  input  logic             req_sabt,
  input  logic             route_irq,
  input  logic             route_fiq,
  input  logic             route_abt,
  input  logic             abt_nomask,
  input  logic             abt_vec_async,
  output logic             take_sabt,
  output logic             take_aerr,
  output logic             take_fiq,
  output logic             take_irq,
  output logic [1:0]       vec_cls
);
  route_cfg_t      cfg;
  logic [NSRC-1:0] req_vec;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic            at_top;
  logic [NSRC-1:0] take_q;
  vec_cls_e        vec_q;

  always_comb begin
    cfg               = '{irq: route_irq, fiq: route_fiq, abt: route_abt,
                          nomask: abt_nomask, abt_vec_async: abt_vec_async};
    req_vec           = '0;
    req_vec[SRC_SABT] = req_sabt;
    req_vec[SRC_AERR] = req_aerr;
    req_vec[SRC_FIQ]  = req_fiq;
    req_vec[SRC_IRQ]  = req_irq;
  end

  exr_qualify #(.LVL_W(LVL_W)) u_qual (
    .cur_lvl  (cur_lvl),
    .pmask_abt(pmask_abt),
    .req      (req_vec),
    .cfg      (cfg),
    .at_top   (at_top),
    .elig     (elig)
  );

  exr_arbiter u_arb (
    .elig (elig),
    .grant(grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= '0;
      vec_q  <= VC_SYNC;
    end else begin
      take_q <= grant;
      vec_q  <= vec_of(grant, cfg.abt_vec_async);
    end
  end

  assign take_sabt = take_q[SRC_SABT];
  assign take_aerr = take_q[SRC_AERR];
  assign take_fiq  = take_q[SRC_FIQ];
  assign take_irq  = take_q[SRC_IRQ];
  assign vec_cls   = vec_q;

  // ---------------- assertions ----------------
  assert_irq_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(req_irq & route_irq));

  assert_fiq_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_fiq |-> $past(req_fiq & route_fiq));

  assert_aerr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_aerr |-> $past(route_abt));

  assert_aerr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_aerr & route_abt & at_top & pmask_abt & ~abt_nomask) |=> !take_aerr);

  assert_sabt_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sabt & at_top) |=> take_sabt);

  assert_sabt_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_sabt |-> (vec_cls == ($past(abt_vec_async) ? 2'b11 : 2'b00)));

  assert_one_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_sabt, take_aerr, take_fiq, take_irq}));

  assert_idle_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_sabt | take_aerr | take_fiq | take_irq) |-> (vec_cls == 2'b00));
endmodule

// File: tb/exr_route_top_tb.sv
module exr_route_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] cur_lvl = '0;
  logic pmask_abt = 0, req_irq = 0, req_fiq = 0, req_aerr = 0, req_sabt = 0;
  logic route_irq = 0, route_fiq = 0, route_abt = 0, abt_nomask = 0, abt_vec_async = 0;
  logic take_sabt, take_aerr, take_fiq, take_irq;
  logic [1:0] vec_cls;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exr_route_top #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .pmask_abt(pmask_abt),
    .req_irq(req_irq), .req_fiq(req_fiq), .req_aerr(req_aerr), .req_sabt(req_sabt),
    .route_irq(route_irq), .route_fiq(route_fiq), .route_abt(route_abt),
    .abt_nomask(abt_nomask), .abt_vec_async(abt_vec_async),
    .take_sabt(take_sabt), .take_aerr(take_aerr), .take_fiq(take_fiq),
    .take_irq(take_irq), .vec_cls(vec_cls)
  );

  // expected {take_sabt,take_aerr,take_fiq,take_irq,vec_cls} from the requirements
  function automatic logic [5:0] model(logic [1:0] lvl, logic pm, logic [3:0] rq, logic [4:0] cf);
    logic mon;
    mon = (lvl == 2'd3);
    // rq = {sabt,aerr,fiq,irq}; cf = {ri,rf,ra,nm,avs}
    if (rq[3] && (mon || cf[2]))                    return {4'b1000, cf[0] ? 2'b11 : 2'b00};
    if (rq[2] && cf[2] && (!mon || !pm || cf[1]))  return {4'b0100, 2'b11};
    if (rq[1] && cf[3])                             return {4'b0010, 2'b10};
    if (rq[0] && cf[4])                             return {4'b0001, 2'b01};
    return 6'b0;
  endfunction

  function automatic logic [5:0] observed();
    return {take_sabt, take_aerr, take_fiq, take_irq, vec_cls};
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // drive at negedge, the registered result is visible at the next negedge
  task automatic drive(logic [1:0] lvl, logic pm, logic [3:0] rq, logic [4:0] cf);
    cur_lvl = lvl; pmask_abt = pm;
    {req_sabt, req_aerr, req_fiq, req_irq} = rq;
    {route_irq, route_fiq, route_abt, abt_nomask, abt_vec_async} = cf;
    @(negedge clk);
  endtask

  task automatic step_chk(string tag, logic [1:0] lvl, logic pm, logic [3:0] rq,
                          logic [4:0] cf, logic [5:0] exp);
    drive(lvl, pm, rq, cf);
    check(tag, observed(), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in reset", observed(), 6'b0);
    rst_n = 1'b1;
    step_chk("R1 after release", 2'd0, 0, 4'b0000, 5'b00000, 6'b0);
  endtask

  task automatic t_irq_fiq();
    step_chk("R2 irq routed lvl1",   2'd1, 0, 4'b0001, 5'b10000, 6'b000101);
    step_chk("R2 irq routed lvl3",   2'd3, 0, 4'b0001, 5'b10000, 6'b000101);
    step_chk("R2 irq unrouted lvl3", 2'd3, 0, 4'b0001, 5'b01110, 6'b0);
    step_chk("R2 irq unrouted lvl0", 2'd0, 0, 4'b0001, 5'b00000, 6'b0);
    step_chk("R3 fiq routed lvl3",   2'd3, 1, 4'b0010, 5'b01000, 6'b001010);
    step_chk("R3 fiq unrouted lvl2", 2'd2, 0, 4'b0010, 5'b10110, 6'b0);
  endtask

  task automatic t_aerr();
    step_chk("R4 aerr unrouted lvl1", 2'd1, 0, 4'b0100, 5'b00010, 6'b0);
    step_chk("R4 aerr routed lvl2 masked", 2'd2, 1, 4'b0100, 5'b00100, 6'b010011);
    step_chk("R5 aerr lvl3 masked held", 2'd3, 1, 4'b0100, 5'b00100, 6'b0);
    step_chk("R5 aerr lvl3 nomask", 2'd3, 1, 4'b0100, 5'b00110, 6'b010011);
    step_chk("R5 aerr lvl3 unmasked", 2'd3, 0, 4'b0100, 5'b00100, 6'b010011);
    step_chk("R11 nomask ignored unrouted", 2'd3, 1, 4'b0100, 5'b00010, 6'b0);
    step_chk("R11 nomask ignored unrouted clear", 2'd3, 0, 4'b0100, 5'b00010, 6'b0);
  endtask

  task automatic t_sabt();
    step_chk("R6 sabt lvl3 unrouted", 2'd3, 0, 4'b1000, 5'b00000, 6'b100000);
    step_chk("R6 sabt lvl0 unrouted", 2'd0, 0, 4'b1000, 5'b00000, 6'b0);
    step_chk("R6 sabt lvl0 routed",   2'd0, 0, 4'b1000, 5'b00100, 6'b100000);
    step_chk("R7 sabt async vector",  2'd3, 0, 4'b1000, 5'b00001, 6'b100011);
    step_chk("R8 idle code",          2'd3, 0, 4'b0000, 5'b11111, 6'b0);
  endtask

  task automatic t_priority();
    step_chk("R9 all qualify", 2'd1, 0, 4'b1111, 5'b11100, 6'b100000);
    step_chk("R9 aerr over fiq", 2'd1, 0, 4'b0111, 5'b11100, 6'b010011);
    step_chk("R9 fiq over irq", 2'd1, 0, 4'b0011, 5'b11000, 6'b001010);
    step_chk("R9 held aerr lets irq", 2'd3, 1, 4'b0101, 5'b10100, 6'b000101);
  endtask

  task automatic t_pending();
    for (int k = 0; k < 3; k++)
      step_chk("R10 held while masked", 2'd3, 1, 4'b0100, 5'b00100, 6'b0);
    step_chk("R10 taken after unmask", 2'd3, 0, 4'b0100, 5'b00100, 6'b010011);
    step_chk("R10 retaken while high", 2'd3, 0, 4'b0100, 5'b00100, 6'b010011);
    step_chk("R10 held unrouted irq", 2'd2, 0, 4'b0001, 5'b00000, 6'b0);
    step_chk("R10 dropped before routing", 2'd2, 0, 4'b0000, 5'b10000, 6'b0);
    step_chk("R10 routing later, irq taken", 2'd2, 0, 4'b0001, 5'b10000, 6'b000101);
  endtask

  task automatic t_sweep();
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 16; r++)
          for (int c = 0; c < 32; c++) begin
            drive(l[1:0], p[0], r[3:0], c[4:0]);
            check("R9 sweep", observed(), model(l[1:0], p[0], r[3:0], c[4:0]));
          end
  endtask

  initial begin
    t_reset();
    t_irq_fiq();
    t_aerr();
    t_sabt();
    t_priority();
    t_pending();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule